// File: doc/BRIEF.md
# Damped Oscillator Heun Integrator

This block advances a damped spring-mass system by one time step per request. The second-order equation x'' = -(k/m)x - (d/m)x' is carried as two coupled first-order states: a position state and a velocity state. Every value is held in signed 32-bit fixed point with 16 fraction bits. That format spans -32768.0 up to just below +32768.0 in steps of 2^-16.

Software first loads five registers through a small write port while the engine is idle: the stiffness ratio k/m, the damping ratio d/m, the step size dt, and the two initial states. Each step request then runs a predictor-corrector (Heun) update. The engine evaluates the slopes at the current point and forms a trial point one step ahead with those slopes. It evaluates the slopes again at the trial point, and then advances both states by dt times the mean of the two slope pairs. A single fixed-point multiplier is shared across the eight products a step needs, under a short sequencer. When the step finishes, the new states appear on the outputs together with a one-cycle valid pulse.

Top module: `heun_engine`

## Requirements
- R1: While reset is low at a clock edge, the engine returns to idle: both state outputs read zero, and busy and out_valid are low on the following cycle.
- R2: A write with cfg_we high while busy is low loads the register chosen by cfg_sel: 0 is k/m, 1 is d/m, 2 is dt, 3 is the position state, 4 is the velocity state. Writes to 3 and 4 appear on v1_out or v2_out one cycle later. Codes 5 to 7 change nothing.
- R3: Every fixed-point product takes the full signed 64-bit product of two 32-bit operands and keeps bits 47:16, which truncates toward minus infinity.
- R4: One step computes, in this order: kv1 = v2 and kv2 = -(k/m)v1 - (d/m)v2. It then forms the trial point v1t = v1 + dt*kv1 and v2t = v2 + dt*kv2. Next it forms mv1 = v2t and mv2 = -(k/m)v1t - (d/m)v2t. Finally v1 += dt*h1 and v2 += dt*h2, where h1 = (kv1+mv1)>>>1 and h2 = (kv2+mv2)>>>1 are formed from 33-bit sums. All results wrap to 32 bits.
- R5: A request is accepted at a clock edge where step_req is high and busy is low. out_valid is then high for exactly one cycle, starting after the 8th following edge. busy stays high from the acceptance edge until out_valid drops.
- R6: step_req while busy is ignored: no further step and no further out_valid pulse result from it.
- R7: Configuration writes while busy are ignored and do not affect the step in progress or later steps.
- R8: v1_out and v2_out change only on a position or velocity write (R2) or when out_valid rises.
- R9: With k/m = 1, d/m = 0.25, dt = 1/32, v1 = 1 and v2 = 0, the position output stays within 0.004 of the analytic damped sinusoid for 160 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe, honoured only when idle |
| cfg_sel | input | 3 | Register select for the write (see R2) |
| cfg_data | input | 32 | Write value, s15.16 |
| step_req | input | 1 | Request one integration step |
| busy | output | 1 | Step in progress |
| out_valid | output | 1 | One-cycle pulse: new states are on the outputs |
| v1_out | output | 32 | Position state, s15.16 |
| v2_out | output | 32 | Velocity state, s15.16 |

## Verification
The bench builds the engine with its default 32-bit word and 16 fraction bits. With that word size, a 64-bit integer model in the bench reproduces every product and halving bit for bit, so each step result can be compared exactly. That covers the floor rounding of negative products and odd-valued sums before the halving. The same widths make the 1/32 step practical, so a long run can also be judged against the closed-form damped cosine. That run exposes drift that a per-step comparison cannot show.

// File: rtl/heun_pkg.sv
// Shared types for the Heun integrator: sequencer phases and write-select codes.
// Assumes nothing beyond IEEE 1800-2017 enums.
package heun_pkg;

    // Sequencer phases; each working phase spends two cycles (sub 0 and 1).
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SLOPE1  = 3'd1,
        ST_PREDICT = 3'd2,
        ST_SLOPE2  = 3'd3,
        ST_CORRECT = 3'd4,
        ST_DONE    = 3'd5
    } phase_e;

    // Configuration register select codes.
    typedef enum logic [2:0] {
        SEL_KM = 3'd0,
        SEL_DM = 3'd1,
        SEL_DT = 3'd2,
        SEL_V1 = 3'd3,
        SEL_V2 = 3'd4
    } cfg_sel_e;

    // Number of sub-steps in a working phase.
    localparam int SUBS_PER_PHASE = 2;

endpackage

// File: rtl/heun_mul.sv
// Shared fixed-point multiplier.
// Forms the full signed product of two W-bit operands and returns it shifted
// right arithmetically by F, truncated to W bits (floor rounding).
// Assumes W >= F and 2*W fits the synthesis multiplier width.
module heun_mul #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] prod
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] full;

    // Sign-extend, multiply, and keep the middle W bits.
    always_comb begin
        a_ext = PW'(op_a);
        b_ext = PW'(op_b);
        full  = a_ext * b_ext;
        prod  = W'(full >>> F);
    end

endmodule

// File: rtl/heun_seq.sv
// Step sequencer for the Heun integrator.
// Walks SLOPE1, PREDICT, SLOPE2 and CORRECT, two cycles each, then DONE for one
// cycle. Requests arriving while not idle are dropped.
// Assumes step_req is synchronous to clk.
module heun_seq
    import heun_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_req,
    output phase_e phase,
    output logic   sub,
    output logic   busy,
    output logic   out_valid
);
    phase_e nxt_work;

    // Order of the working phases after the second sub-step.
    always_comb begin
        case (phase)
            ST_SLOPE1:  nxt_work = ST_PREDICT;
            ST_PREDICT: nxt_work = ST_SLOPE2;
            ST_SLOPE2:  nxt_work = ST_CORRECT;
            ST_CORRECT: nxt_work = ST_DONE;
            default:    nxt_work = ST_IDLE;
        endcase
    end

    // Phase and sub-step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
            sub   <= 1'b0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    sub <= 1'b0;
                    if (step_req) phase <= ST_SLOPE1;
                end
                ST_DONE: begin
                    sub   <= 1'b0;
                    phase <= ST_IDLE;
                end
                default: begin
                    if (!sub) begin
                        sub <= 1'b1;
                    end else begin
                        sub   <= 1'b0;
                        phase <= nxt_work;
                    end
                end
            endcase
        end
    end

    // Status decodes.
    always_comb begin
        busy      = (phase != ST_IDLE);
        out_valid = (phase == ST_DONE);
    end

endmodule

// File: rtl/heun_datapath.sv
// Register file and update logic for the Heun integrator.
// Holds the coefficients, the states and the intermediate slopes. Each cycle it
// steers one operand pair to the shared multiplier and folds the product into
// the register that the current phase and sub-step names.
// Assumes the product arrives combinationally in the same cycle.
module heun_datapath
    import heun_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase,
    input  logic                sub,
    input  logic                busy,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [W-1:0]        cfg_data,
    input  logic signed [W-1:0] mul_p,
    output logic signed [W-1:0] mul_a,
    output logic signed [W-1:0] mul_b,
    output logic [W-1:0]        v1_out,
    output logic [W-1:0]        v2_out
);
    localparam int SW = W + 1;

    logic signed [W-1:0]  km_r, dm_r, dt_r;
    logic signed [W-1:0]  v1_r, v2_r;
    logic signed [W-1:0]  kv1_r, kv2_r, v1t_r, v2t_r, mv2_r, acc_r;
    logic signed [W-1:0]  v1_q, v2_q;
    logic signed [SW-1:0] sum1, sum2;
    logic signed [W-1:0]  half1, half2;

    // Mean of the two slope estimates, from a widened sum so no carry is lost.
    always_comb begin
        sum1  = SW'(kv1_r) + SW'(v2t_r);
        sum2  = SW'(kv2_r) + SW'(mv2_r);
        half1 = W'(sum1 >>> 1);
        half2 = W'(sum2 >>> 1);
    end

    // Operand steering for the shared multiplier.
    always_comb begin
        case (phase)
            ST_SLOPE1: begin
                mul_a = sub ? dm_r : km_r;
                mul_b = sub ? v2_r : v1_r;
            end
            ST_PREDICT: begin
                mul_a = dt_r;
                mul_b = sub ? kv2_r : kv1_r;
            end
            ST_SLOPE2: begin
                mul_a = sub ? dm_r  : km_r;
                mul_b = sub ? v2t_r : v1t_r;
            end
            ST_CORRECT: begin
                mul_a = dt_r;
                mul_b = sub ? half2 : half1;
            end
            default: begin
                mul_a = '0;
                mul_b = '0;
            end
        endcase
    end

    // Configuration loads when idle, otherwise the per-phase updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            km_r  <= '0;
            dm_r  <= '0;
            dt_r  <= '0;
            v1_r  <= '0;
            v2_r  <= '0;
            kv1_r <= '0;
            kv2_r <= '0;
            v1t_r <= '0;
            v2t_r <= '0;
            mv2_r <= '0;
            acc_r <= '0;
            v1_q  <= '0;
            v2_q  <= '0;
        end else if (!busy) begin
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_KM: km_r <= $signed(cfg_data);
                    SEL_DM: dm_r <= $signed(cfg_data);
                    SEL_DT: dt_r <= $signed(cfg_data);
                    SEL_V1: begin
                        v1_r <= $signed(cfg_data);
                        v1_q <= $signed(cfg_data);
                    end
                    SEL_V2: begin
                        v2_r <= $signed(cfg_data);
                        v2_q <= $signed(cfg_data);
                    end
                    default: ;
                endcase
            end
        end else begin
            case (phase)
                ST_SLOPE1: begin
                    if (!sub) begin
                        acc_r <= -mul_p;
                        kv1_r <= v2_r;
                    end else begin
                        kv2_r <= acc_r - mul_p;
                    end
                end
                ST_PREDICT: begin
                    if (!sub) v1t_r <= v1_r + mul_p;
                    else      v2t_r <= v2_r + mul_p;
                end
                ST_SLOPE2: begin
                    if (!sub) acc_r <= -mul_p;
                    else      mv2_r <= acc_r - mul_p;
                end
                ST_CORRECT: begin
                    if (!sub) begin
                        v1_r <= v1_r + mul_p;
                    end else begin
                        v2_r <= v2_r + mul_p;
                        v1_q <= v1_r;
                        v2_q <= v2_r + mul_p;
                    end
                end
                default: ;
            endcase
        end
    end

    // Published states.
    always_comb begin
        v1_out = v1_q;
        v2_out = v2_q;
    end

endmodule

// File: rtl/heun_engine.sv
// Top level of the damped-oscillator Heun integrator.
// Connects the sequencer, the datapath and one shared multiplier.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module heun_engine #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_sel,
    input  logic [W-1:0] cfg_data,
    input  logic         step_req,
    output logic         busy,
    output logic         out_valid,
    output logic [W-1:0] v1_out,
    output logic [W-1:0] v2_out
);
    import heun_pkg::*;

    phase_e              phase;
    logic                sub;
    logic signed [W-1:0] mul_a, mul_b, mul_p;

    heun_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .phase     (phase),
        .sub       (sub),
        .busy      (busy),
        .out_valid (out_valid)
    );

    heun_mul #(.W(W), .F(F)) u_mul (
        .op_a (mul_a),
        .op_b (mul_b),
        .prod (mul_p)
    );

    heun_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .sub      (sub),
        .busy     (busy),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .mul_p    (mul_p),
        .mul_a    (mul_a),
        .mul_b    (mul_b),
        .v1_out   (v1_out),
        .v2_out   (v2_out)
    );

endmodule

// File: rtl/heun_engine_chk.sv
// Port-level checker for the Heun integrator, bound to every heun_engine.
// Tracks the cycles since an accepted request with its own counter.
module heun_engine_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_we,
    input logic [2:0]   cfg_sel,
    input logic [W-1:0] cfg_data,
    input logic         step_req,
    input logic         busy,
    input logic         out_valid,
    input logic [W-1:0] v1_out,
    input logic [W-1:0] v2_out
);
    localparam logic [3:0] LAT = 4'd9;

    logic [3:0] lat_cnt;

    // Counts cycles from an accepted request to its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lat_cnt <= '0;
        else if (step_req && !busy) lat_cnt <= 4'd1;
        else if (out_valid)         lat_cnt <= '0;
        else if (lat_cnt != 4'd0)   lat_cnt <= lat_cnt + 4'd1;
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !out_valid && v1_out == '0 && v2_out == '0));

    // R2
    v1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy && cfg_sel == 3'd3) |=> (v1_out == $past(cfg_data)));

    // R2
    v2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy && cfg_sel == 3'd4) |=> (v2_out == $past(cfg_data)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_cnt == LAT));

    // R5
    lat_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == LAT) |-> out_valid);

    // R6
    run_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_valid) |=> busy);

    // R8
    v1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v1_out) |-> (out_valid || $past(cfg_we && !busy && cfg_sel == 3'd3)));

    // R8
    v2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v2_out) |-> (out_valid || $past(cfg_we && !busy && cfg_sel == 3'd4)));

endmodule

bind heun_engine heun_engine_chk #(.W(W)) u_chk (.*);

// File: tb/heun_engine_tb.sv
module heun_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        step_req = 1'b0;
    logic        busy, out_valid;
    logic [31:0] v1_out, v2_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    logic signed [31:0] m_km, m_dm, m_dt, m_v1, m_v2;
    logic signed [31:0] q_v1[$];
    logic signed [31:0] q_v2[$];
    bit  ana_on = 1'b0;
    int  ana_n = 0;
    real ana_a, ana_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    heun_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .step_req(step_req), .busy(busy),
        .out_valid(out_valid), .v1_out(v1_out), .v2_out(v2_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 product rule: full signed product, bits 47:16.
    function automatic logic signed [31:0] fm(input logic signed [31:0] a, input logic signed [31:0] b);
        longint pr;
        pr = longint'(a) * longint'(b);
        return 32'(pr >>> 16);
    endfunction

    function automatic logic signed [31:0] hf(input logic signed [31:0] a, input logic signed [31:0] b);
        longint s;
        s = longint'(a) + longint'(b);
        return 32'(s >>> 1);
    endfunction

    // R4 one Heun step on the model state.
    task automatic model_step();
        logic signed [31:0] kv1, kv2, v1t, v2t, mv2, h1, h2;
        kv1 = m_v2;
        kv2 = -fm(m_km, m_v1) - fm(m_dm, m_v2);
        v1t = m_v1 + fm(m_dt, kv1);
        v2t = m_v2 + fm(m_dt, kv2);
        mv2 = -fm(m_km, v1t) - fm(m_dm, v2t);
        h1  = hf(kv1, v2t);
        h2  = hf(kv2, mv2);
        m_v1 = m_v1 + fm(m_dt, h1);
        m_v2 = m_v2 + fm(m_dt, h2);
    endtask

    task automatic model_clear();
        m_km = '0; m_dm = '0; m_dt = '0; m_v1 = '0; m_v2 = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        q_v1.delete();
        q_v2.delete();
        // R1 idle state after reset
        chk(v1_out == '0, "R1", v1_out, 0);
        chk(v2_out == '0, "R1", v2_out, 0);
        chk(!busy && !out_valid, "R1", {busy, out_valid}, 0);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        logic [31:0] o1, o2;
        o1 = v1_out;
        o2 = v2_out;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_km = data;
            3'd1: m_dm = data;
            3'd2: m_dt = data;
            3'd3: m_v1 = data;
            3'd4: m_v2 = data;
            default: ;
        endcase
        // R2 visible load or no change
        if (sel == 3'd3) chk(v1_out == data, "R2", v1_out, data);
        else             chk(v1_out == o1, "R2", v1_out, o1);
        if (sel == 3'd4) chk(v2_out == data, "R2", v2_out, data);
        else             chk(v2_out == o2, "R2", v2_out, o2);
    endtask

    // Driver: pushes the expected result, requests a step, checks timing.
    task automatic run_step(input bit poke_req, input bit poke_cfg);
        logic [31:0] o1, o2;
        int k;
        o1 = v1_out;
        o2 = v2_out;
        model_step();
        q_v1.push_back(m_v1);
        q_v2.push_back(m_v2);
        @(negedge clk);
        step_req = 1'b1;
        k = 0;
        while (k < 20) begin
            @(negedge clk);
            k++;
            if (k == 1) step_req = 1'b0;
            if (k == 3) begin
                if (poke_req) step_req = 1'b1;        // R6
                if (poke_cfg) begin                    // R7
                    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 32'h7FFF_0000;
                end
            end
            if (k == 4) begin
                step_req = 1'b0;
                cfg_we = 1'b0;
            end
            if (out_valid) break;
            // R8 outputs held during the step
            chk(v1_out == o1 && v2_out == o2, "R8", v1_out, o1);
            // R5 busy through the step
            chk(busy, "R5", busy, 1);
        end
        // R5 valid arrives after 8 edges past acceptance
        chk(k == 9, "R5", k, 9);
        @(negedge clk);
        // R5 single-cycle pulse, back to idle
        chk(!out_valid && !busy, "R5", {out_valid, busy}, 0);
    endtask

    // Monitor: pops and compares every completed step.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_v1.size() == 0) begin
                chk(1'b0, "R6", 1, 0);
            end else begin
                logic signed [31:0] e1, e2;
                e1 = q_v1.pop_front();
                e2 = q_v2.pop_front();
                // R4 bit-exact step result
                chk(v1_out == e1, "R4", $signed(v1_out), e1);
                chk(v2_out == e2, "R4", $signed(v2_out), e2);
                if (ana_on) begin
                    real t, x, err;
                    ana_n++;
                    t = ana_n / 32.0;
                    x = $exp(-ana_a * t) * ($cos(ana_wd * t) + (ana_a / ana_wd) * $sin(ana_wd * t));
                    err = $itor($signed(v1_out)) / 65536.0 - x;
                    if (err < 0.0) err = -err;
                    // R9 tracks the analytic damped sinusoid
                    chk(err <= 0.004, "R9", longint'(err * 1.0e6), 4000);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        model_clear();
        do_reset();

        // R2 register loads
        cfg_write(3'd0, 32'h0002_0000);
        cfg_write(3'd1, 32'h0000_2000);
        cfg_write(3'd2, 32'h0000_0800);
        cfg_write(3'd3, 32'h0000_8000);
        cfg_write(3'd4, 32'hFFFF_0000);
        cfg_write(3'd5, 32'h1234_5678);   // R2 unused code ignored
        cfg_write(3'd7, 32'hDEAD_BEEF);
        repeat (3) run_step(1'b0, 1'b0);

        // R6 request while busy, R7 write while busy
        run_step(1'b1, 1'b0);
        repeat (12) @(negedge clk);
        chk(!busy && !out_valid && q_v1.size() == 0, "R6", busy, 0);
        run_step(1'b0, 1'b1);
        run_step(1'b0, 1'b0);             // R7 stiffness untouched afterwards

        // R3 floor rounding of negative and odd products
        cfg_write(3'd0, 32'h0001_8000);
        cfg_write(3'd1, 32'hFFFF_8000);
        cfg_write(3'd2, 32'h0001_0000);
        cfg_write(3'd3, 32'hFFFF_FFFF);
        cfg_write(3'd4, 32'h0000_0001);
        repeat (2) run_step(1'b0, 1'b0);

        // R4 larger magnitudes
        cfg_write(3'd0, 32'h0064_0000);
        cfg_write(3'd1, 32'h0003_4000);
        cfg_write(3'd2, 32'h0000_1000);
        cfg_write(3'd3, 32'hFFB0_0000);
        cfg_write(3'd4, 32'h0123_4567);
        repeat (3) run_step(1'b0, 1'b0);

        // R1 reset in the middle of a step
        @(negedge clk);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();

        // R9 long run against the closed form
        ana_a  = 0.125;
        ana_wd = $sqrt(1.0 - ana_a * ana_a);
        cfg_write(3'd0, 32'h0001_0000);
        cfg_write(3'd1, 32'h0000_4000);
        cfg_write(3'd2, 32'h0000_0800);
        cfg_write(3'd3, 32'h0001_0000);
        cfg_write(3'd4, 32'h0000_0000);
        ana_on = 1'b1;
        ana_n  = 0;
        repeat (160) run_step(1'b0, 1'b0);
        ana_on = 1'b0;
        chk(ana_n == 160, "R9", ana_n, 160);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule